// File: doc/BRIEF.md
# JTAG Register Access Chain

This block lets debug software read and write a bank of 32-bit configuration registers through a JTAG test access port. A 16-state TAP controller follows TMS on every rising TCK edge. A 4-bit instruction register picks which data path sits between TDI and TDO, and a separate chain select register, loaded by its own instruction, names the chain the access instruction reaches. When that select register holds 6, the access instruction inserts a 40-bit packet register. Each packet holds a data word, a register address and a direction bit.

Every access is committed when the controller passes through Update-DR. A write drives a one-cycle strobe on a plain register bus in the TCK domain. A read samples the bus read data into a holding register. The next Capture-DR loads that held value into the packet, so the result leaves on the following scan. Addresses at or above the parameter `NUM_REGS` have no register behind them. The block blocks writes to them and turns reads from them into zero.

TAP states: Test-Logic-Reset (`ST_RESET`), Run-Test/Idle (`ST_IDLE`), Select-DR (`ST_DR_SEL`), Capture-DR (`ST_DR_CAP`), Shift-DR (`ST_DR_SHIFT`), Exit1-DR (`ST_DR_EXIT1`), Pause-DR (`ST_DR_PAUSE`), Exit2-DR (`ST_DR_EXIT2`), Update-DR (`ST_DR_UPD`), and the IR counterparts `ST_IR_SEL`, `ST_IR_CAP`, `ST_IR_SHIFT`, `ST_IR_EXIT1`, `ST_IR_PAUSE`, `ST_IR_EXIT2`, `ST_IR_UPD`.

Transitions are written here as state: next state with TMS=1 / next state with TMS=0.
- RESET: RESET / IDLE
- IDLE: DR_SEL / IDLE
- DR_SEL: IR_SEL / DR_CAP
- DR_CAP: DR_EXIT1 / DR_SHIFT
- DR_SHIFT: DR_EXIT1 / DR_SHIFT
- DR_EXIT1: DR_UPD / DR_PAUSE
- DR_PAUSE: DR_EXIT2 / DR_PAUSE
- DR_EXIT2: DR_UPD / DR_SHIFT
- DR_UPD: DR_SEL / IDLE
- IR_SEL: RESET / IR_CAP

The IR states move in the same pattern as the DR states, and IR_UPD leaves to DR_SEL / IDLE.

Top module: `jtag_regbus_chain`

## Requirements
- R1: Driving trst_n low puts the controller in Test-Logic-Reset at once. Five consecutive rising TCK edges with TMS high also reach Test-Logic-Reset from any state. While the controller is in Test-Logic-Reset, the instruction becomes the bypass code 4'hF and the chain select register becomes 0.
- R2: The instruction register is 4 bits wide. Capture-IR loads 4'b0001 into it. The code 4'hF selects bypass, 4'h2 selects the chain select register and 4'hC selects register access. Every other code selects the 1-bit bypass.
- R3: Under code 4'h2, the 4-bit chain select register is the data path. Capture-DR loads its current value into the shift stage, and Update-DR makes the shifted value current.
- R4: Under code 4'hC, the 40-bit packet is the data path only when the chain select register holds 6. Otherwise a 1-bit bypass is used. The bypass captures 0 and delays TDI by one shift.
- R5: The packet holds data in bits 31:0, the address in bits 38:32 and the direction in bit 39. Bit 0 is shifted in and out first. Capture-DR loads the held read value into bits 31:0 and zero into bits 39:32.
- R6: A packet with direction 1 raises bus_we for exactly the one TCK cycle spent in Update-DR. During that cycle, bus_addr carries the address field and bus_wdata carries the data field. The bank takes the write on the rising edge that leaves Update-DR.
- R7: A packet with direction 0 raises no strobe, and its data field has no effect. The edge that leaves Update-DR samples bus_rdata into the held read value, which comes out in bits 31:0 of the next scan.
- R8: An address of NUM_REGS (12 by default) or above never raises bus_we, and a read from such an address holds zero.
- R9: bus_we stays low in every state other than Update-DR, and whenever the data path is not the packet.
- R10: TDO is 0 outside Shift-IR and Shift-DR. In those two states it shows bit 0 of the register on the selected path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data into the selected path |
| tdo | output | 1 | Serial data out of the selected path |
| bus_addr | output | 7 | Register bus address, taken from the packet address field |
| bus_wdata | output | 32 | Register bus write data, taken from the packet data field |
| bus_we | output | 1 | Register bus write strobe, one TCK cycle wide |
| bus_rdata | input | 32 | Register bus read data for bus_addr |

## Verification
Each result is due at a fixed cycle:
- The TDO bit for a shift cycle comes from registers set on the previous rising edge. The bench drives TMS and TDI just after the falling edge and samples TDO 1 ns later, in the same cycle.
- The write strobe, address and data belong to the single cycle in Update-DR. The bench samples them in that cycle's low phase and nowhere else.
- A read result is due one full scan after the request. The read sweep is therefore pipelined: every scan checks the data owed by the previous address and asks for the next. Both sweeps cover all 128 addresses.

// File: rtl/jtag_chain_pkg.sv
`timescale 1ns/1ps
package jtag_chain_pkg;

    // Sixteen controller states
    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPD
    } tap_state_e;

    // Per-state action enables handed to the register units
    typedef struct packed {
        logic in_reset;
        logic dr_cap;
        logic dr_shift;
        logic dr_upd;
        logic ir_cap;
        logic ir_shift;
        logic ir_upd;
    } tap_ctl_t;

    // Which data register sits between TDI and TDO
    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_CHSEL,
        PATH_PACKET
    } dr_path_e;

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_chain_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    tap_state_e next_state;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_RESET:    next_state = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     next_state = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   next_state = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   next_state = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: next_state = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: next_state = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: next_state = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: next_state = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   next_state = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   next_state = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   next_state = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: next_state = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: next_state = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: next_state = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: next_state = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   next_state = tms ? ST_DR_SEL   : ST_IDLE;
            default:     next_state = ST_RESET;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RESET:    ctl.in_reset = 1'b1;
            ST_DR_CAP:   ctl.dr_cap   = 1'b1;
            ST_DR_SHIFT: ctl.dr_shift = 1'b1;
            ST_DR_UPD:   ctl.dr_upd   = 1'b1;
            ST_IR_CAP:   ctl.ir_cap   = 1'b1;
            ST_IR_SHIFT: ctl.ir_shift = 1'b1;
            ST_IR_UPD:   ctl.ir_upd   = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/jtag_instr_unit.sv
`timescale 1ns/1ps
module jtag_instr_unit
    import jtag_chain_pkg::*;
#(
    parameter int IR_W      = 4,
    parameter int SEL_W     = 4,
    parameter int IR_SELECT = 2,
    parameter int IR_ACCESS = 12,
    parameter int CHAIN_ID  = 6
) (
    input  logic     tck,
    input  logic     trst_n,
    input  tap_ctl_t ctl,
    input  logic     tdi,
    output dr_path_e path,
    output logic     ir_tdo,
    output logic     chsel_tdo
);

    localparam logic [IR_W-1:0]  IR_BYPASS  = '1;
    localparam logic [IR_W-1:0]  IR_CAPTURE = IR_W'(1);
    localparam logic [IR_W-1:0]  SEL_CODE   = IR_W'(IR_SELECT);
    localparam logic [IR_W-1:0]  ACC_CODE   = IR_W'(IR_ACCESS);
    localparam logic [SEL_W-1:0] SEL_MATCH  = SEL_W'(CHAIN_ID);

    logic [IR_W-1:0]  ir_sh;
    logic [IR_W-1:0]  ir_q;
    logic [SEL_W-1:0] sel_sh;
    logic [SEL_W-1:0] sel_q;
    logic             on_sel;

    // Instruction shift stage and current instruction
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= '0;
            ir_q  <= IR_BYPASS;
        end else begin
            if (ctl.ir_cap)        ir_sh <= IR_CAPTURE;
            else if (ctl.ir_shift) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (ctl.in_reset)      ir_q  <= IR_BYPASS;
            else if (ctl.ir_upd)   ir_q  <= ir_sh;
        end
    end

    assign on_sel = (path == PATH_CHSEL);

    // Chain select shift stage and current chain number
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sel_sh <= '0;
            sel_q  <= '0;
        end else begin
            if (ctl.dr_cap && on_sel)        sel_sh <= sel_q;
            else if (ctl.dr_shift && on_sel) sel_sh <= {tdi, sel_sh[SEL_W-1:1]};
            if (ctl.in_reset)                sel_q  <= '0;
            else if (ctl.dr_upd && on_sel)   sel_q  <= sel_sh;
        end
    end

    always_comb begin
        if (ir_q == SEL_CODE)
            path = PATH_CHSEL;
        else if (ir_q == ACC_CODE && sel_q == SEL_MATCH)
            path = PATH_PACKET;
        else
            path = PATH_BYPASS;
    end

    assign ir_tdo    = ir_sh[0];
    assign chsel_tdo = sel_sh[0];

endmodule

// File: rtl/jtag_packet_dr.sv
`timescale 1ns/1ps
module jtag_packet_dr
    import jtag_chain_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 12
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_ctl_t          ctl,
    input  logic              active,
    input  logic              tdi,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              pkt_tdo
);

    localparam int                PKT_W      = DATA_W + ADDR_W + 1;
    localparam logic [ADDR_W:0]   ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [PKT_W-1:0]  pkt_q;
    logic [DATA_W-1:0] rd_hold_q;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              f_rw;
    logic              mapped;

    assign f_data = pkt_q[DATA_W-1:0];
    assign f_addr = pkt_q[DATA_W +: ADDR_W];
    assign f_rw   = pkt_q[PKT_W-1];
    assign mapped = ({1'b0, f_addr} < ADDR_LIMIT);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            pkt_q     <= '0;
            rd_hold_q <= '0;
        end else begin
            if (active && ctl.dr_cap)
                pkt_q <= {{(ADDR_W+1){1'b0}}, rd_hold_q};
            else if (active && ctl.dr_shift)
                pkt_q <= {tdi, pkt_q[PKT_W-1:1]};
            if (active && ctl.dr_upd && !f_rw)
                rd_hold_q <= mapped ? bus_rdata : '0;
        end
    end

    assign bus_we    = active && ctl.dr_upd && f_rw && mapped;
    assign bus_addr  = f_addr;
    assign bus_wdata = f_data;
    assign pkt_tdo   = pkt_q[0];

endmodule

// File: rtl/jtag_regbus_chain.sv
`timescale 1ns/1ps
module jtag_regbus_chain
    import jtag_chain_pkg::*;
#(
    parameter int IR_W      = 4,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int NUM_REGS  = 12,
    parameter int CHAIN_ID  = 6,
    parameter int IR_SELECT = 2,
    parameter int IR_ACCESS = 12
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic [DATA_W-1:0] bus_rdata
);

    tap_state_e tap_state;
    tap_ctl_t   ctl;
    dr_path_e   dr_path;
    logic       ir_tdo;
    logic       chsel_tdo;
    logic       pkt_tdo;
    logic       bypass_q;
    logic       pkt_active;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state),
        .ctl    (ctl)
    );

    jtag_instr_unit #(
        .IR_W      (IR_W),
        .SEL_W     (SEL_W),
        .IR_SELECT (IR_SELECT),
        .IR_ACCESS (IR_ACCESS),
        .CHAIN_ID  (CHAIN_ID)
    ) u_instr (
        .tck       (tck),
        .trst_n    (trst_n),
        .ctl       (ctl),
        .tdi       (tdi),
        .path      (dr_path),
        .ir_tdo    (ir_tdo),
        .chsel_tdo (chsel_tdo)
    );

    assign pkt_active = (dr_path == PATH_PACKET);

    jtag_packet_dr #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_pkt (
        .tck       (tck),
        .trst_n    (trst_n),
        .ctl       (ctl),
        .active    (pkt_active),
        .tdi       (tdi),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .pkt_tdo   (pkt_tdo)
    );

    // One-bit bypass path
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            bypass_q <= 1'b0;
        else if (ctl.dr_cap && dr_path == PATH_BYPASS)
            bypass_q <= 1'b0;
        else if (ctl.dr_shift && dr_path == PATH_BYPASS)
            bypass_q <= tdi;
    end

    always_comb begin
        tdo = 1'b0;
        if (tap_state == ST_IR_SHIFT) begin
            tdo = ir_tdo;
        end else if (tap_state == ST_DR_SHIFT) begin
            unique case (dr_path)
                PATH_CHSEL:  tdo = chsel_tdo;
                PATH_PACKET: tdo = pkt_tdo;
                default:     tdo = bypass_q;
            endcase
        end
    end

endmodule

// File: rtl/jtag_regbus_chain_chk.sv
`timescale 1ns/1ps
module jtag_regbus_chain_chk
    import jtag_chain_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 12
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              tdo,
    input tap_state_e        state,
    input dr_path_e          path,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr
);

    logic [2:0] hi_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            hi_run <= '0;
        else if (!tms)          hi_run <= '0;
        else if (hi_run != 3'd4) hi_run <= hi_run + 3'd1;
    end

    assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && hi_run == 3'd4) |=> (state == ST_RESET));

    assert_reset_bypass_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (path == PATH_BYPASS));

    assert_we_path_R4: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |-> (path == PATH_PACKET));

    assert_we_pulse_R6: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |=> !bus_we);

    assert_we_mapped_R8: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |-> ({1'b0, bus_addr} < (ADDR_W+1)'(NUM_REGS)));

    assert_we_update_R9: assert property (@(posedge tck) disable iff (!trst_n)
        bus_we |-> (state == ST_DR_UPD));

    assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_DR_SHIFT && state != ST_IR_SHIFT) |-> (tdo == 1'b0));

endmodule

bind jtag_regbus_chain jtag_regbus_chain_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tdo      (tdo),
    .state    (tap_state),
    .path     (dr_path),
    .bus_we   (bus_we),
    .bus_addr (bus_addr)
);

// File: tb/jtag_regbus_chain_bench.sv
`timescale 1ns/1ps
module jtag_regbus_chain_bench;

    localparam int NREG  = 12;
    localparam int NADDR = 128;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad   = 0;
    int we_count = 0;
    logic finished = 1'b0;

    logic        s_we;
    logic [6:0]  s_addr;
    logic [31:0] s_wdata;
    logic        u_we;
    logic [6:0]  u_addr;
    logic [31:0] u_wdata;

    logic [31:0] bank [NADDR];

    jtag_regbus_chain u_jtag_regbus_chain (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .tdo       (tdo),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata)
    );

    always #2 tck = ~tck;

    // Bench register bank: every address answers, the block must mask
    initial begin
        for (int i = 0; i < NADDR; i++) bank[i] = 32'hDEAD_0000 | i;
    end
    assign bus_rdata = bank[bus_addr];
    always @(posedge tck) begin
        if (bus_we) begin
            bank[bus_addr] <= bus_wdata;
            we_count++;
        end
    end

    function automatic logic [31:0] pat(input int a);
        return 32'h1F2E_3D4C ^ (a * 32'h0101_0103);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        #1;
        o       = tdo;
        s_we    = bus_we;
        s_addr  = bus_addr;
        s_wdata = bus_wdata;
    endtask

    task automatic scan_ir(input logic [3:0] v, output logic [3:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, v[i], o);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int n, input logic [39:0] din, output logic [39:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        u_we    = s_we;
        u_addr  = s_addr;
        u_wdata = s_wdata;
    endtask

    task automatic bypass_chk(input string req, input logic [7:0] v);
        logic [39:0] d;
        scan_dr(8, {32'h0, v}, d);
        chk(req, "one-bit delay path", d, {32'h0, v[6:0], 1'b0});
        chk(req, "no strobe on bypass", {39'h0, u_we}, 40'h0);
    endtask

    task automatic set_chain(input logic [3:0] c);
        logic [3:0]  cap;
        logic [39:0] d;
        scan_ir(4'h2, cap);
        scan_dr(4, {36'h0, c}, d);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [39:0] d;
        logic        o;
        int          wexp;
        logic [31:0] exp_d;

        #9;
        chk("R10", "tdo in reset", {39'h0, tdo}, 40'h0);
        chk("R9", "bus_we in reset", {39'h0, bus_we}, 40'h0);
        @(negedge tck);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o);

        // R2: capture pattern and bypass code
        scan_ir(4'hF, cap);
        chk("R2", "IR capture", {36'h0, cap}, 40'h1);
        bypass_chk("R4", 8'hB6);

        // R3: chain select capture and update
        scan_ir(4'h2, cap);
        scan_dr(4, 40'h6, d);
        chk("R3", "select after reset", d, 40'h0);
        scan_dr(4, 40'h6, d);
        chk("R3", "select readback", d, 40'h6);

        // R5/R6/R8: write sweep over the whole address space
        scan_ir(4'hC, cap);
        wexp = 0;
        for (int a = 0; a < NADDR; a++) begin
            scan_dr(40, {1'b1, 7'(a), pat(a)}, d);
            chk("R5", "capture on write scan", d, 40'h0);
            if (a < NREG) begin
                wexp++;
                chk("R6", "strobe", {39'h0, u_we}, 40'h1);
                chk("R5", "addr field", {33'h0, u_addr}, {33'h0, 7'(a)});
                chk("R5", "data field", {8'h0, u_wdata}, {8'h0, pat(a)});
            end else begin
                chk("R8", "no strobe unmapped", {39'h0, u_we}, 40'h0);
            end
        end
        chk("R6", "one pulse per mapped write", 40'(we_count), 40'(wexp));

        // R7/R8: pipelined read sweep, data field carries garbage
        for (int a = 0; a <= NADDR; a++) begin
            scan_dr(40, {1'b0, 7'(a % NADDR), ~pat(a)}, d);
            if (a == 0) exp_d = 32'h0;
            else if (a - 1 < NREG) exp_d = pat(a - 1);
            else exp_d = 32'h0;
            chk((a - 1 < NREG) ? "R7" : "R8", "read result", d, {8'h0, exp_d});
            chk("R7", "no strobe on read", {39'h0, u_we}, 40'h0);
        end
        chk("R7", "reads leave bank", 40'(we_count), 40'(wexp));
        chk("R7", "bank 0 intact", {8'h0, bank[0]}, {8'h0, pat(0)});

        // R4: access code with chain other than 6 -> bypass
        set_chain(4'h3);
        scan_ir(4'hC, cap);
        bypass_chk("R4", 8'h5A);

        // R2: unknown code -> bypass
        scan_ir(4'h5, cap);
        bypass_chk("R2", 8'hC3);

        // R1: five TMS-high edges from idle
        set_chain(4'h6);
        scan_ir(4'hC, cap);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        bypass_chk("R1", 8'h39);
        scan_ir(4'h2, cap);
        scan_dr(4, 40'h0, d);
        chk("R1", "chain select cleared by TMS", d, 40'h0);

        // R1: asynchronous reset in the middle of a scan
        set_chain(4'h6);
        scan_ir(4'hC, cap);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b1, o);
        #0.5;
        trst_n = 1'b0;
        #1;
        chk("R10", "tdo after trst", {39'h0, tdo}, 40'h0);
        @(negedge tck);
        trst_n = 1'b1;
        step(1'b0, 1'b0, o);
        bypass_chk("R1", 8'h71);
        chk("R1", "no strobe through trst", 40'(we_count), 40'(wexp));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule